// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the execute stage of a small 8-bit accumulator machine. Each cycle it may accept one 16-bit instruction word together with the working register value, the byte fetched from the register file and the present carry bit. It decodes the operation from the upper bits of the word and computes a result byte. It also decides whether that byte is written back to the working register or to the file register. Finally it gives fresh values for the five status flags with a mask that shows which of them the operation is allowed to change.

The operations are: addition, with or without the incoming carry; three forms of subtraction; increment and decrement; two's-complement negation; the bitwise operations AND, OR, XOR and complement; a plain move; rotation left and right, with or without the carry; exchange of the two nibbles; and the constant loads clear and set. The register file, its banking and any multiplier lie outside the block. The instruction's address byte and access bit pass through unused. The result is registered, so outputs for an instruction presented in one cycle appear after the next rising clock edge.

Top module: `byteAlu`

## Requirements
- R1: Bits 15:10 of the instruction word select the operation. For operations that have a destination bit, bit 9 routes the result: 0 raises wrW, 1 raises wrFile. The two strobes are never high together. Bits 8:0 have no effect on any output.
- R2: Opcode 001001 gives W+F. Opcode 001000 gives W+F+C. C is the carry out of bit 7, DC the carry out of bit 3 and OV the signed overflow. The mask is 11111.
- R3: Opcode 010111 gives F-W. Opcode 010110 gives F-W-(1-C). Opcode 010101 gives W-F-(1-C). C and DC mean "no borrow" out of bit 7 and out of bit 3. OV is the signed overflow. The mask is 11111.
- R4: Opcode 001010 gives F+1 and opcode 000001 gives F-1. C, DC and OV follow the addition rule or the no-borrow rule of R2 and R3. The mask is 11111.
- R5: Code 0110110 in bits 15:9 gives 0-F. It always writes the file register. The flags follow the R3 rule and the mask is 11111.
- R6: The logic operations and the move update only Z and N (mask 10100). AND is 000101, OR is 000100, XOR is 000110, complement is 000111 and move is 010100.
- R7: Rotates through carry update C, Z and N (mask 10101). Opcode 001101 rotates left: C takes bit 7 and bit 0 takes the old C. Opcode 001100 rotates right: C takes bit 0 and bit 7 takes the old C. Rotates without carry use mask 10100: 010001 rotates left and 010000 rotates right.
- R8: Opcode 001110 exchanges the nibbles of F and leaves every flag untouched (mask 00000).
- R9: Code 0110101 clears: the result is 00h, the file register is written, the mask is 00100 and Z is 1. Code 0110100 sets: the result is FFh, the file register is written and the mask is 00000.
- R10: The flag buses are ordered bit 4 N, bit 3 OV, bit 2 Z, bit 1 DC, bit 0 C. Z is 1 when the result is zero and N is result bit 7. A flagNext bit outside flagMask is 0.
- R11: Any other code leaves both write strobes low, and gives result 00h and mask 00000. Examples are 0110111, 0000 00x, 0000 1xx, 0110 0xx, 0111 xxx and 1xxx xxx.
- R12: resValid follows instrValid one clock later. When resValid is low, both strobes are low. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| wReg | input | 8 | Working register value |
| fOpd | input | 8 | File register operand byte |
| carryIn | input | 1 | Current carry flag |
| resValid | output | 1 | Registered outputs belong to an instruction |
| resByte | output | 8 | Result byte |
| wrW | output | 1 | Write the result into the working register |
| wrFile | output | 1 | Write the result into the file register |
| flagNext | output | 5 | New flag values {N, OV, Z, DC, C}, zero outside mask |
| flagMask | output | 5 | Flags this operation updates |

## Verification
Random operands rarely produce the points where DC and OV flip. Examples are 7Fh+1, 80h-1, negating 80h and a nibble borrow that depends only on the incoming carry. Random operands also almost never reach the undefined codes that lie between the defined ones. The stimulus therefore sweeps every value of bits 15:9 against a fixed set of edge operand pairs. It uses both carry values and random address bits, and only then adds random traffic. Each result is compared with an arithmetic reference that works on signed and unsigned integers, not on bit slices.

// File: rtl/byteAluPkg.sv
package byteAluPkg;

  localparam int FLG_W  = 5;
  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;

  localparam logic [FLG_W-1:0] MASK_ALL  = 5'b11111;
  localparam logic [FLG_W-1:0] MASK_ZN   = 5'b10100;
  localparam logic [FLG_W-1:0] MASK_CZN  = 5'b10101;
  localparam logic [FLG_W-1:0] MASK_Z    = 5'b00100;
  localparam logic [FLG_W-1:0] MASK_NONE = 5'b00000;

  localparam int OPC_W = 7;  // operation code plus destination bit

  typedef enum logic [3:0] {
    RS_ADDER, RS_AND, RS_OR, RS_XOR, RS_COM, RS_MOV,
    RS_RLC, RS_RLN, RS_RRC, RS_RRN, RS_SWAP, RS_CLR, RS_SET, RS_NONE
  } resSel_e;

  typedef enum logic [1:0] { OA_W, OA_F, OA_ZERO } opA_e;
  typedef enum logic [2:0] { OB_F, OB_NOTW, OB_NOTF, OB_ZERO, OB_ONES } opB_e;
  typedef enum logic [1:0] { CI_ZERO, CI_ONE, CI_CARRY } cin_e;

  typedef struct packed {
    resSel_e          resSel;
    opA_e             opA;
    opB_e             opB;
    cin_e             cinSel;
    logic             toW;
    logic             toFile;
    logic [FLG_W-1:0] mask;
  } aluCtrl_t;

endpackage

// File: rtl/baluDecode.sv
module baluDecode
  import byteAluPkg::*;
(
  input  logic [OPC_W-1:0] opField,
  output aluCtrl_t         ctrl
);

  logic [OPC_W-2:0] opc;
  logic             dBit;
  logic             useD;

  assign opc  = opField[OPC_W-1:1];
  assign dBit = opField[0];

  always_comb begin
    ctrl = '{resSel: RS_NONE, opA: OA_W, opB: OB_F, cinSel: CI_ZERO,
             toW: 1'b0, toFile: 1'b0, mask: MASK_NONE};
    useD = 1'b0;
    case (opc)
      6'b001001: begin
        ctrl.resSel = RS_ADDER; ctrl.mask = MASK_ALL; useD = 1'b1;
      end
      6'b001000: begin
        ctrl.resSel = RS_ADDER; ctrl.cinSel = CI_CARRY;
        ctrl.mask = MASK_ALL; useD = 1'b1;
      end
      6'b010111: begin
        ctrl.resSel = RS_ADDER; ctrl.opA = OA_F; ctrl.opB = OB_NOTW;
        ctrl.cinSel = CI_ONE; ctrl.mask = MASK_ALL; useD = 1'b1;
      end
      6'b010110: begin
        ctrl.resSel = RS_ADDER; ctrl.opA = OA_F; ctrl.opB = OB_NOTW;
        ctrl.cinSel = CI_CARRY; ctrl.mask = MASK_ALL; useD = 1'b1;
      end
      6'b010101: begin
        ctrl.resSel = RS_ADDER; ctrl.opA = OA_W; ctrl.opB = OB_NOTF;
        ctrl.cinSel = CI_CARRY; ctrl.mask = MASK_ALL; useD = 1'b1;
      end
      6'b001010: begin
        ctrl.resSel = RS_ADDER; ctrl.opA = OA_F; ctrl.opB = OB_ZERO;
        ctrl.cinSel = CI_ONE; ctrl.mask = MASK_ALL; useD = 1'b1;
      end
      6'b000001: begin
        ctrl.resSel = RS_ADDER; ctrl.opA = OA_F; ctrl.opB = OB_ONES;
        ctrl.mask = MASK_ALL; useD = 1'b1;
      end
      6'b000101: begin ctrl.resSel = RS_AND;  ctrl.mask = MASK_ZN;  useD = 1'b1; end
      6'b000100: begin ctrl.resSel = RS_OR;   ctrl.mask = MASK_ZN;  useD = 1'b1; end
      6'b000110: begin ctrl.resSel = RS_XOR;  ctrl.mask = MASK_ZN;  useD = 1'b1; end
      6'b000111: begin ctrl.resSel = RS_COM;  ctrl.mask = MASK_ZN;  useD = 1'b1; end
      6'b010100: begin ctrl.resSel = RS_MOV;  ctrl.mask = MASK_ZN;  useD = 1'b1; end
      6'b001101: begin ctrl.resSel = RS_RLC;  ctrl.mask = MASK_CZN; useD = 1'b1; end
      6'b010001: begin ctrl.resSel = RS_RLN;  ctrl.mask = MASK_ZN;  useD = 1'b1; end
      6'b001100: begin ctrl.resSel = RS_RRC;  ctrl.mask = MASK_CZN; useD = 1'b1; end
      6'b010000: begin ctrl.resSel = RS_RRN;  ctrl.mask = MASK_ZN;  useD = 1'b1; end
      6'b001110: begin ctrl.resSel = RS_SWAP; ctrl.mask = MASK_NONE; useD = 1'b1; end
      6'b011010: begin
        ctrl.toFile = 1'b1;
        if (dBit) begin
          ctrl.resSel = RS_CLR; ctrl.mask = MASK_Z;
        end else begin
          ctrl.resSel = RS_SET; ctrl.mask = MASK_NONE;
        end
      end
      6'b011011: begin
        if (!dBit) begin
          ctrl.resSel = RS_ADDER; ctrl.opA = OA_ZERO; ctrl.opB = OB_NOTF;
          ctrl.cinSel = CI_ONE; ctrl.mask = MASK_ALL; ctrl.toFile = 1'b1;
        end
      end
      default: ;
    endcase
    if (useD) begin
      ctrl.toW    = !dBit;
      ctrl.toFile = dBit;
    end
  end

endmodule

// File: rtl/baluAdder.sv
module baluAdder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cOut,
  output logic              hCarry,
  output logic              ovf
);

  localparam int HALF_W = DATA_W / 2;
  localparam int HIGH_W = DATA_W - HALF_W;
  localparam int MSB    = DATA_W - 1;

  logic [HALF_W:0] lowSum;
  logic [HIGH_W:0] highSum;

  assign lowSum  = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin};
  assign highSum = {1'b0, a[MSB:HALF_W]} + {1'b0, b[MSB:HALF_W]}
                 + {{HIGH_W{1'b0}}, lowSum[HALF_W]};

  assign sum    = {highSum[HIGH_W-1:0], lowSum[HALF_W-1:0]};
  assign cOut   = highSum[HIGH_W];
  assign hCarry = lowSum[HALF_W];
  assign ovf    = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

endmodule

// File: rtl/baluDatapath.sv
module baluDatapath
  import byteAluPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] wReg,
  input  logic [DATA_W-1:0] fOpd,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic [FLG_W-1:0]  flags
);

  localparam int MSB    = DATA_W - 1;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] opA, opB, sum;
  logic              cin, cOut, hCarry, ovf;
  logic              carryFlag;
  logic [FLG_W-1:0]  rawFlags;

  always_comb begin
    case (ctrl.opA)
      OA_W:    opA = wReg;
      OA_F:    opA = fOpd;
      default: opA = '0;
    endcase
    case (ctrl.opB)
      OB_F:    opB = fOpd;
      OB_NOTW: opB = ~wReg;
      OB_NOTF: opB = ~fOpd;
      OB_ONES: opB = '1;
      default: opB = '0;
    endcase
    case (ctrl.cinSel)
      CI_ONE:   cin = 1'b1;
      CI_CARRY: cin = carryIn;
      default:  cin = 1'b0;
    endcase
  end

  baluAdder #(.DATA_W(DATA_W)) adder_i (
    .a(opA), .b(opB), .cin(cin),
    .sum(sum), .cOut(cOut), .hCarry(hCarry), .ovf(ovf)
  );

  always_comb begin
    case (ctrl.resSel)
      RS_ADDER: result = sum;
      RS_AND:   result = wReg & fOpd;
      RS_OR:    result = wReg | fOpd;
      RS_XOR:   result = wReg ^ fOpd;
      RS_COM:   result = ~fOpd;
      RS_MOV:   result = fOpd;
      RS_RLC:   result = {fOpd[MSB-1:0], carryIn};
      RS_RLN:   result = {fOpd[MSB-1:0], fOpd[MSB]};
      RS_RRC:   result = {carryIn, fOpd[MSB:1]};
      RS_RRN:   result = {fOpd[0], fOpd[MSB:1]};
      RS_SWAP:  result = {fOpd[HALF_W-1:0], fOpd[MSB:HALF_W]};
      RS_SET:   result = '1;
      default:  result = '0;
    endcase
  end

  always_comb begin
    case (ctrl.resSel)
      RS_RLC:  carryFlag = fOpd[MSB];
      RS_RRC:  carryFlag = fOpd[0];
      default: carryFlag = cOut;
    endcase
    rawFlags          = '0;
    rawFlags[FLG_C]   = carryFlag;
    rawFlags[FLG_DC]  = hCarry;
    rawFlags[FLG_Z]   = (result == '0);
    rawFlags[FLG_OV]  = ovf;
    rawFlags[FLG_N]   = result[MSB];
    flags             = rawFlags & ctrl.mask;
  end

endmodule

// File: rtl/byteAlu.sv
module byteAlu
  import byteAluPkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  wReg,
  input  logic [DATA_W-1:0]  fOpd,
  input  logic               carryIn,
  output logic               resValid,
  output logic [DATA_W-1:0]  resByte,
  output logic               wrW,
  output logic               wrFile,
  output logic [FLG_W-1:0]   flagNext,
  output logic [FLG_W-1:0]   flagMask
);

  localparam int OP_LO = INSTR_W - OPC_W;

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] aluResult;
  logic [FLG_W-1:0]  aluFlags;
  logic              unusedInstr;

  assign unusedInstr = ^instr[OP_LO-1:0];

  baluDecode decode_i (
    .opField(instr[INSTR_W-1:OP_LO]),
    .ctrl(ctrl)
  );

  baluDatapath #(.DATA_W(DATA_W)) dpath_i (
    .ctrl(ctrl), .wReg(wReg), .fOpd(fOpd), .carryIn(carryIn),
    .result(aluResult), .flags(aluFlags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resByte  <= '0;
      wrW      <= 1'b0;
      wrFile   <= 1'b0;
      flagNext <= '0;
      flagMask <= '0;
    end else begin
      resValid <= instrValid;
      wrW      <= instrValid && ctrl.toW;
      wrFile   <= instrValid && ctrl.toFile;
      if (instrValid) begin
        resByte  <= aluResult;
        flagNext <= aluFlags;
        flagMask <= ctrl.mask;
      end
    end
  end

endmodule

// File: rtl/byteAluChk.sv
module byteAluChk #(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               instrValid,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  fOpd,
  input logic               resValid,
  input logic [DATA_W-1:0]  resByte,
  input logic               wrW,
  input logic               wrFile,
  input logic [4:0]         flagNext,
  input logic [4:0]         flagMask
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  logic [6:0] top7;
  assign top7 = instr[INSTR_W-1 -: 7];

  // R1: the two write strobes are exclusive
  p_dest_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(wrW && wrFile));

  // R12: no strobe without a valid result
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !resValid |-> (!wrW && !wrFile));

  // R12: valid follows the input valid one cycle later
  p_valid_follow_r12: assert property (@(posedge clk) disable iff (rst)
    instrValid |=> resValid);

  // R10: bits outside the mask stay clear
  p_mask_clean_r10: assert property (@(posedge clk) disable iff (rst)
    (flagNext & ~flagMask) == 5'b0);

  // R10: zero flag agrees with the result byte
  p_zero_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (resValid && flagMask[2]) |-> (flagNext[2] == (resByte == '0)));

  // R10: negative flag agrees with the result sign bit
  p_neg_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (resValid && flagMask[4]) |-> (flagNext[4] == resByte[MSB]));

  // R9: clear writes zero to the file with only Z, set
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (instrValid && top7 == 7'b0110101) |=>
      (wrFile && !wrW && resByte == '0 && flagMask == 5'b00100 && flagNext == 5'b00100));

  // R8: nibble exchange, no flags
  p_swap_r8: assert property (@(posedge clk) disable iff (rst)
    (instrValid && top7[6:1] == 6'b001110) |=>
      (flagMask == 5'b0 && resByte == {$past(fOpd[HALF_W-1:0]), $past(fOpd[MSB:HALF_W])}));

  // R4: increment of all ones wraps with C, DC and Z set
  p_inc_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (instrValid && top7[6:1] == 6'b001010 && fOpd == '1) |=>
      (resByte == '0 && flagNext[0] && flagNext[1] && flagNext[2]));

endmodule

bind byteAlu byteAluChk #(.INSTR_W(INSTR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr), .fOpd(fOpd),
  .resValid(resValid), .resByte(resByte), .wrW(wrW), .wrFile(wrFile),
  .flagNext(flagNext), .flagMask(flagMask)
);

// File: tb/byteAlu_tb_top.sv
`timescale 1ns/100ps
module byteAlu_tb_top;

  typedef struct {
    logic [7:0]  res;
    logic        ww;
    logic        wf;
    logic [4:0]  fl;
    logic [4:0]  mk;
    string       tag;
    logic [15:0] ins;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  wReg = '0;
  logic [7:0]  fOpd = '0;
  logic        carryIn = 1'b0;
  logic        resValid, wrW, wrFile;
  logic [7:0]  resByte;
  logic [4:0]  flagNext, flagMask;

  int   total = 0;
  int   bad = 0;
  bit   finished = 1'b0;
  exp_t sb[$];
  exp_t monE;

  always #2.5 clk = ~clk;

  byteAlu dut_i (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr),
    .wReg(wReg), .fOpd(fOpd), .carryIn(carryIn),
    .resValid(resValid), .resByte(resByte), .wrW(wrW), .wrFile(wrFile),
    .flagNext(flagNext), .flagMask(flagMask)
  );

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic void addRef(input int x, input int y, input int ci,
                                 output int r, output bit cf, output bit dc, output bit ov);
    int s, ss;
    s  = x + y + ci;
    r  = s & 255;
    cf = (s > 255);
    dc = (((x & 15) + (y & 15) + ci) > 15);
    ss = sgn(x) + sgn(y) + ci;
    ov = (ss > 127) || (ss < -128);
  endfunction

  function automatic void subRef(input int x, input int y, input int bi,
                                 output int r, output bit cf, output bit dc, output bit ov);
    int s, ss;
    s  = x - y - bi;
    r  = s & 255;
    cf = (s >= 0);
    dc = (((x & 15) - (y & 15) - bi) >= 0);
    ss = sgn(x) - sgn(y) - bi;
    ov = (ss > 127) || (ss < -128);
  endfunction

  function automatic exp_t model(logic [15:0] ins, logic [7:0] w, logic [7:0] f, logic c);
    exp_t e;
    int   r, wi, fi, ci;
    bit   cf, dc, ov, z, n;
    int   dst;  // 0 by d bit, 1 file, 2 none
    wi = int'(w); fi = int'(f); ci = c ? 1 : 0;
    r = 0; cf = 0; dc = 0; ov = 0; dst = 0;
    e.mk = 5'b00000; e.tag = "R11"; e.ins = ins;
    case (ins[15:10])
      6'b001001: begin addRef(wi, fi, 0, r, cf, dc, ov);  e.mk = 5'b11111; e.tag = "R2"; end
      6'b001000: begin addRef(wi, fi, ci, r, cf, dc, ov); e.mk = 5'b11111; e.tag = "R2"; end
      6'b010111: begin subRef(fi, wi, 0, r, cf, dc, ov);    e.mk = 5'b11111; e.tag = "R3"; end
      6'b010110: begin subRef(fi, wi, 1-ci, r, cf, dc, ov); e.mk = 5'b11111; e.tag = "R3"; end
      6'b010101: begin subRef(wi, fi, 1-ci, r, cf, dc, ov); e.mk = 5'b11111; e.tag = "R3"; end
      6'b001010: begin addRef(fi, 1, 0, r, cf, dc, ov); e.mk = 5'b11111; e.tag = "R4"; end
      6'b000001: begin subRef(fi, 1, 0, r, cf, dc, ov); e.mk = 5'b11111; e.tag = "R4"; end
      6'b000101: begin r = wi & fi;       e.mk = 5'b10100; e.tag = "R6"; end
      6'b000100: begin r = wi | fi;       e.mk = 5'b10100; e.tag = "R6"; end
      6'b000110: begin r = wi ^ fi;       e.mk = 5'b10100; e.tag = "R6"; end
      6'b000111: begin r = 255 - fi;      e.mk = 5'b10100; e.tag = "R6"; end
      6'b010100: begin r = fi;            e.mk = 5'b10100; e.tag = "R6"; end
      6'b001101: begin r = ((fi * 2) & 255) + ci;     cf = f[7]; e.mk = 5'b10101; e.tag = "R7"; end
      6'b010001: begin r = ((fi * 2) & 255) + f[7];              e.mk = 5'b10100; e.tag = "R7"; end
      6'b001100: begin r = (fi / 2) + 128 * ci;       cf = f[0]; e.mk = 5'b10101; e.tag = "R7"; end
      6'b010000: begin r = (fi / 2) + 128 * f[0];                e.mk = 5'b10100; e.tag = "R7"; end
      6'b001110: begin r = (fi % 16) * 16 + fi / 16;             e.mk = 5'b00000; e.tag = "R8"; end
      6'b011010: begin
        dst = 1; e.tag = "R9";
        if (ins[9]) begin r = 0; e.mk = 5'b00100; end
        else        begin r = 255; e.mk = 5'b00000; end
      end
      6'b011011: begin
        if (!ins[9]) begin subRef(0, fi, 0, r, cf, dc, ov); e.mk = 5'b11111; e.tag = "R5"; dst = 1; end
        else dst = 2;
      end
      default: dst = 2;
    endcase
    if (dst == 2) r = 0;
    e.res = r[7:0];
    e.ww  = (dst == 0) && !ins[9];
    e.wf  = (dst == 1) || ((dst == 0) && ins[9]);
    z = (e.res == 8'h00);
    n = e.res[7];
    e.fl = {n, ov, z, dc, cf} & e.mk;
    return e;
  endfunction

  task automatic send(logic [15:0] ins, logic [7:0] w, logic [7:0] f, logic c);
    @(negedge clk);
    instrValid = 1'b1;
    instr = ins; wReg = w; fOpd = f; carryIn = c;
    sb.push_back(model(ins, w, f, c));
  endtask

  task automatic idle();
    @(negedge clk);
    instrValid = 1'b0;
    instr = 16'($urandom); wReg = 8'($urandom); fOpd = 8'($urandom);
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (resValid) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R12 result valid with nothing pending: act=1 exp=0");
        end else begin
          monE = sb.pop_front();
          if (resByte !== monE.res) begin
            bad++;
            $display("FAIL %s result ins=%h act=%h exp=%h", monE.tag, monE.ins, resByte, monE.res);
          end
          total++;
          if ({wrW, wrFile} !== {monE.ww, monE.wf}) begin
            bad++;
            $display("FAIL R1 (%s) dest ins=%h act=%b exp=%b", monE.tag, monE.ins,
                     {wrW, wrFile}, {monE.ww, monE.wf});
          end
          total++;
          if ({flagNext, flagMask} !== {monE.fl, monE.mk}) begin
            bad++;
            $display("FAIL R10 (%s) flags ins=%h act=%b/%b exp=%b/%b", monE.tag, monE.ins,
                     flagNext, flagMask, monE.fl, monE.mk);
          end
        end
      end else begin
        total++;
        if (wrW || wrFile) begin
          bad++;
          $display("FAIL R12 strobes while idle: act=%b exp=00", {wrW, wrFile});
        end
      end
    end
  end

  initial begin
    logic [7:0] cw [8];
    logic [7:0] cf [8];
    cw = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h0F, 8'h01, 8'h55, 8'hA3};
    cf = '{8'h00, 8'h01, 8'h01, 8'h80, 8'h01, 8'hFF, 8'hAA, 8'h5C};
    instr = 16'hFFFF; wReg = 8'hFF; fOpd = 8'hFF; carryIn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    total++;
    if ({resValid, resByte, wrW, wrFile, flagNext, flagMask} !== '0) begin
      bad++;
      $display("FAIL R12 reset state act=%b exp=0",
               {resValid, resByte, wrW, wrFile, flagNext, flagMask});
    end
    rst = 1'b0;
    // sweep every code of bits 15:9 over edge operands, both carries
    for (int op = 0; op < 128; op++) begin
      for (int k = 0; k < 8; k++) begin
        send({7'(op), 9'($urandom)}, cw[k], cf[k], 1'(k));
        send({7'(op), 9'($urandom)}, cf[k], cw[k], 1'(~k));
      end
      if (op % 16 == 0) idle();
    end
    // same operation, different address and access bits (R1)
    for (int k = 0; k < 16; k++) begin
      send({7'b0010011, 9'($urandom)}, 8'h3C, 8'hC5, 1'b0);
    end
    // random traffic
    for (int k = 0; k < 600; k++) begin
      send(16'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
      if ($urandom % 8 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R12 results missing: act=%0d pending exp=0", sb.size());
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL R12 watchdog expired: act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule